// File: doc/BRIEF.md
# Shared Forward/Inverse Byte Substitution Unit

This block substitutes one byte per clock through either the forward cipher S-box or its inverse, as chosen by a mode bit that travels alongside the byte. Both directions share one multiplicative inverter. The inverter does not work in the standard byte field defined by the polynomial {11B}. It works in a composite field built as a quadratic extension of GF(2^4). Each direction has its own linear layer on each side of the inverter. On the input side, the forward path applies only the basis change into the composite field. The inverse path applies the inverse affine step and the basis change as one combined matrix and constant. On the output side, the forward path applies the basis change back together with the affine step and its constant {63}. The inverse path applies only the basis change back.

The basis change matrices, their inverse, the extension constant and the merged matrices are all derived from the field definitions when the design elaborates, so the RTL carries no hand-entered matrix. An output register is present by default, which gives a latency of one cycle. It can be removed by parameter, and the unit is then purely combinational.

Top module: `sbox_shared`

## Requirements
- R1: While `rst_n` is low, `dout` reads {00}. After reset is released, `dout` stays {00} until the first byte has been captured.
- R2: With `mode` = 1 (forward), `dout` one cycle after a byte is presented equals the forward S-box of that byte. The forward S-box takes the multiplicative inverse modulo {11B}, with {00} mapped to {00}. It then applies the affine step: XOR of the byte with its rotations left by 1, 2, 3 and 4 bits, then XOR with {63}. Examples: {01}→{7C}, {53}→{ED}.
- R3: With `mode` = 0 (inverse), `dout` one cycle after a byte is presented equals the inverse S-box of that byte. The inverse S-box applies the inverse affine step: XOR of the rotations left by 1, 3 and 6 bits, then XOR with {05}. It then takes the multiplicative inverse modulo {11B}.
- R4: A zero operand reaching the inverter gives zero. So forward {00} gives {63}, and inverse {63} gives {00}.
- R5: Feeding any forward result back in inverse mode returns the original byte, for all 256 byte values.
- R6: Each result uses the mode that was presented together with its byte. The mode may change on every cycle without corrupting either neighbouring result.
- R7: The output never equals the byte that produced it, in either mode. In forward mode it also never equals the bitwise complement of that byte.
- R8: While `din` and `mode` are held constant, `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mode | input | 1 | 1 = forward substitution, 0 = inverse substitution |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte, one cycle after `din` |

## Verification
The bench builds the unit with its default parameter, which keeps the output register. Every result therefore lands exactly one cycle after its byte, and a fresh byte with either mode can be streamed on every clock. This makes it possible to sweep all 256 values in both directions and to alternate the mode cycle by cycle. It also allows each forward output to be looped back through the inverse path. A combinational reference in the field {11B}, which uses no tables, supplies every expected value.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  typedef logic [7:0]  byte_t;
  typedef logic [3:0]  nib_t;
  typedef logic [63:0] mat8_t;   // column j (image of bit j) at [8*j +: 8]

  typedef struct packed {
    logic fwdIn;    // select forward input layer
    logic fwdOut;   // select forward output layer
  } sboxStrobe_t;

  // GF(2^4) with x^4 + x + 1
  function automatic nib_t gf16Mul(input nib_t a, input nib_t b);
    nib_t p;
    nib_t aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[3] ? ({aa[2:0], 1'b0} ^ 4'h3) : {aa[2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic nib_t gf16Inv(input nib_t a);
    nib_t a2;
    nib_t a4;
    nib_t a8;
    a2 = gf16Mul(a, a);
    a4 = gf16Mul(a2, a2);
    a8 = gf16Mul(a4, a4);
    return gf16Mul(gf16Mul(a2, a4), a8);   // a^14
  endfunction

  // pick lambda so that y^2 + y + lambda has no root in GF(2^4)
  function automatic nib_t findLambda();
    nib_t r;
    logic found;
    logic hasRoot;
    r = '0;
    found = 1'b0;
    for (int l = 1; l < 16; l++) begin
      hasRoot = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf16Mul(nib_t'(t), nib_t'(t)) ^ nib_t'(t)) == nib_t'(l)) hasRoot = 1'b1;
      if (!found && !hasRoot) begin
        r = nib_t'(l);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  localparam nib_t LAMBDA = findLambda();

  // composite element {h,l} = h*y + l, y^2 = y + lambda
  function automatic byte_t cfMul(input byte_t a, input byte_t b);
    nib_t hh;
    nib_t h;
    nib_t l;
    hh = gf16Mul(a[7:4], b[7:4]);
    h  = hh ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]);
    l  = gf16Mul(hh, LAMBDA) ^ gf16Mul(a[3:0], b[3:0]);
    return {h, l};
  endfunction

  // composite element g that satisfies x^8 + x^4 + x^3 + x + 1 = 0
  function automatic byte_t findRoot();
    byte_t r;
    byte_t c;
    byte_t c2;
    byte_t c3;
    byte_t c4;
    byte_t c8;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 2; k < 256; k++) begin
      c  = byte_t'(k);
      c2 = cfMul(c, c);
      c3 = cfMul(c2, c);
      c4 = cfMul(c2, c2);
      c8 = cfMul(c4, c4);
      if (!found && ((c8 ^ c4 ^ c3 ^ c ^ 8'h01) == 8'h00)) begin
        r = c;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic byte_t matApply(input mat8_t m, input byte_t v);
    byte_t r;
    r = '0;
    for (int j = 0; j < 8; j++)
      if (v[j]) r = r ^ m[8*j +: 8];
    return r;
  endfunction

  function automatic mat8_t matMul(input mat8_t a, input mat8_t b);
    mat8_t r;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = matApply(a, b[8*j +: 8]);
    return r;
  endfunction

  function automatic mat8_t matInvert(input mat8_t m);
    mat8_t r;
    r = '0;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 256; b++)
        if (matApply(m, byte_t'(b)) == byte_t'(1 << j)) r[8*j +: 8] = byte_t'(b);
    return r;
  endfunction

  function automatic mat8_t isoCols();
    mat8_t m;
    byte_t g;
    byte_t p;
    g = findRoot();
    p = 8'h01;
    for (int j = 0; j < 8; j++) begin
      m[8*j +: 8] = p;
      p = cfMul(p, g);
    end
    return m;
  endfunction

  function automatic byte_t rotl(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic mat8_t affFwdCols();
    mat8_t m;
    byte_t e;
    for (int j = 0; j < 8; j++) begin
      e = byte_t'(1 << j);
      m[8*j +: 8] = e ^ rotl(e, 1) ^ rotl(e, 2) ^ rotl(e, 3) ^ rotl(e, 4);
    end
    return m;
  endfunction

  function automatic mat8_t affInvCols();
    mat8_t m;
    byte_t e;
    for (int j = 0; j < 8; j++) begin
      e = byte_t'(1 << j);
      m[8*j +: 8] = rotl(e, 1) ^ rotl(e, 3) ^ rotl(e, 6);
    end
    return m;
  endfunction

  localparam byte_t AFF_FWD_C = 8'h63;
  localparam byte_t AFF_INV_C = 8'h05;

  localparam mat8_t ISO     = isoCols();
  localparam mat8_t ISO_INV = matInvert(ISO);

  // merged layers on each side of the inverter
  localparam mat8_t IN_FWD_M  = ISO;
  localparam byte_t IN_FWD_C  = 8'h00;
  localparam mat8_t IN_INV_M  = matMul(ISO, affInvCols());
  localparam byte_t IN_INV_C  = matApply(ISO, AFF_INV_C);
  localparam mat8_t OUT_FWD_M = matMul(affFwdCols(), ISO_INV);
  localparam byte_t OUT_FWD_C = AFF_FWD_C;
  localparam mat8_t OUT_INV_M = ISO_INV;
  localparam byte_t OUT_INV_C = 8'h00;

endpackage

// File: rtl/sbox_lin_layer.sv
module sbox_lin_layer
  import sbox_pkg::*;
#(
  parameter mat8_t MAT  = '0,
  parameter byte_t CNST = '0
) (
  input  byte_t a,
  output byte_t y
);
  always_comb begin
    y = CNST;
    for (int j = 0; j < 8; j++)
      if (a[j]) y = y ^ MAT[8*j +: 8];
  end
endmodule

// File: rtl/sbox_cf_inverter.sv
module sbox_cf_inverter
  import sbox_pkg::*;
(
  input  byte_t a,
  output byte_t y
);
  nib_t hi;
  nib_t lo;
  nib_t norm;
  nib_t normInv;

  always_comb begin
    hi      = a[7:4];
    lo      = a[3:0];
    norm    = gf16Mul(gf16Mul(hi, hi), LAMBDA) ^ gf16Mul(hi, lo) ^ gf16Mul(lo, lo);
    normInv = gf16Inv(norm);
    y       = {gf16Mul(hi, normInv), gf16Mul(hi ^ lo, normInv)};
  end
endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic        mode,
  output sboxStrobe_t strobe
);
  always_comb begin
    strobe.fwdIn  = mode;
    strobe.fwdOut = mode;
  end
endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sboxStrobe_t strobe,
  input  byte_t       din,
  output byte_t       dout
);
  byte_t inFwd;
  byte_t inInv;
  byte_t fieldIn;
  byte_t fieldOut;
  byte_t outFwd;
  byte_t outInv;
  byte_t subVal;

  sbox_lin_layer #(.MAT(IN_FWD_M), .CNST(IN_FWD_C)) u_inFwd (.a(din), .y(inFwd));
  sbox_lin_layer #(.MAT(IN_INV_M), .CNST(IN_INV_C)) u_inInv (.a(din), .y(inInv));

  assign fieldIn = strobe.fwdIn ? inFwd : inInv;

  sbox_cf_inverter u_inv (.a(fieldIn), .y(fieldOut));

  sbox_lin_layer #(.MAT(OUT_FWD_M), .CNST(OUT_FWD_C)) u_outFwd (.a(fieldOut), .y(outFwd));
  sbox_lin_layer #(.MAT(OUT_INV_M), .CNST(OUT_INV_C)) u_outInv (.a(fieldOut), .y(outInv));

  assign subVal = strobe.fwdOut ? outFwd : outInv;

  generate
    if (OUT_REG) begin : g_reg
      byte_t outQ;
      always_ff @(posedge clk) begin
        if (!rst_n) outQ <= '0;
        else        outQ <= subVal;
      end
      assign dout = outQ;
    end else begin : g_comb
      assign dout = subVal;
    end
  endgenerate
endmodule

// File: rtl/sbox_shared.sv
module sbox_shared
  import sbox_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  sboxStrobe_t strobe;

  sbox_ctrl u_ctrl (.mode(mode), .strobe(strobe));

  sbox_datapath #(.OUT_REG(OUT_REG)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .din   (din),
    .dout  (dout)
  );
endmodule

// File: rtl/sbox_shared_checker.sv
module sbox_shared_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode,
  input logic [7:0] din,
  input logic [7:0] dout
);
  // R1: output is clear on the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout == 8'h00));

  // R4: zero into forward path gives {63}
  a_r4_fwd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) && ($past(din) == 8'h00)) |-> (dout == 8'h63));

  // R4: {63} into inverse path gives zero
  a_r4_inv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mode) && ($past(din) == 8'h63)) |-> (dout == 8'h00));

  // R7: no fixed point in either direction
  a_r7_no_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dout != $past(din)));

  // R7: forward output never the complement of its input
  a_r7_no_complement: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode)) |-> (dout != ~$past(din)));

  // R8: held inputs keep the output still
  a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(din) && $stable(mode)) |=> $stable(dout));
endmodule

bind sbox_shared sbox_shared_checker u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .mode (mode),
  .din  (din),
  .dout (dout)
);

// File: tb/sbox_shared_bench.sv
module sbox_shared_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic       pendValid = 1'b0;
  logic [7:0] pendExp = 8'h00;
  string      pendTag = "";

  always #4 clk = ~clk;   // 125 MHz

  sbox_shared u_sbox_shared (.clk(clk), .rst_n(rst_n), .mode(mode), .din(din), .dout(dout));

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [7:0] refInv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 1; k < 256; k++)
      if (refMul(a, 8'(k)) == 8'h01) r = 8'(k);
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic logic [7:0] refFwd(input logic [7:0] x);
    logic [7:0] b;
    b = refInv(x);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] refRev(input logic [7:0] y);
    return refInv(rl(y, 1) ^ rl(y, 3) ^ rl(y, 6) ^ 8'h05);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic checkNe(input string tag, input logic [7:0] got, input logic [7:0] bad);
    nChecks++;
    if (got === bad) begin
      nFails++;
      $display("FAIL %s: actual %02h expected anything but %02h", tag, got, bad);
    end
  endtask

  // drive one byte; check the previous one on the same falling edge
  task automatic step(input logic m, input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    if (pendValid) check(pendTag, dout, pendExp);
    mode = m;
    din = d;
    pendExp = exp;
    pendTag = tag;
    pendValid = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pendValid) check(pendTag, dout, pendExp);
    pendValid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] fwdVal;
    int seedInit;
    seedInit = $urandom(32'd20240611);

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", dout, refFwd(8'h00));

    // R4 and R2 directed
    step(1'b1, 8'h00, 8'h63, "R4 fwd zero");
    step(1'b0, 8'h63, 8'h00, "R4 inv zero");
    step(1'b1, 8'h01, 8'h7C, "R2 fwd 01");
    step(1'b1, 8'h53, 8'hED, "R2 fwd 53");
    step(1'b0, 8'hED, 8'h53, "R3 inv ED");
    flush();

    // R2: forward exhaustive
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i), refFwd(8'(i)), "R2 fwd sweep");
    flush();

    // R3: inverse exhaustive
    for (int i = 0; i < 256; i++) step(1'b0, 8'(i), refRev(8'(i)), "R3 inv sweep");
    flush();

    // R5: loop each forward output back through the inverse path
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 8'(i), refFwd(8'(i)), "R5 fwd leg");
      flush();
      fwdVal = dout;
      step(1'b0, fwdVal, 8'(i), "R5 round trip");
      flush();
    end

    // R6: mode toggling every cycle with random bytes
    for (int i = 0; i < 600; i++) begin
      logic m;
      logic [7:0] d;
      m = (i % 2 == 0) ? 1'b1 : 1'b0;
      if (i % 7 == 3) m = $urandom() % 2 == 1;
      d = 8'($urandom());
      step(m, d, m ? refFwd(d) : refRev(d), "R6 mode stream");
    end
    flush();

    // R7: no fixed point, no forward complement
    for (int i = 0; i < 64; i++) begin
      logic m;
      logic [7:0] d;
      m = $urandom() % 2 == 1;
      d = 8'($urandom());
      @(negedge clk);
      mode = m;
      din = d;
      @(negedge clk);
      got = dout;
      checkNe("R7 fixed point", got, d);
      if (m) checkNe("R7 complement", got, ~d);
    end

    // R8: held inputs keep output still
    @(negedge clk);
    mode = 1'b0;
    din = 8'hA5;
    @(negedge clk);
    got = dout;
    check("R8 first", got, refRev(8'hA5));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 held", dout, got);
    end

    // R1: reset mid-run clears output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", dout, 8'h00);
    rst_n = 1'b1;
    mode = 1'b1;
    din = 8'h10;
    @(negedge clk);
    check("R2 after re-reset", dout, refFwd(8'h10));

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule